// File: doc/BRIEF.md
# Periodic Refresh Scheduler

This block paces refresh work for a DDR3-style SDRAM controller. A cycle counter measures a fixed average refresh interval. Each time the interval elapses, one refresh is added to a count of refreshes owed. While that count is non-zero, a request goes to the command arbiter. Each grant from the arbiter settles one owed refresh. The arbiter may defer refreshes, and the count records how far behind it has fallen. When the count reaches its ceiling, an urgent flag tells the arbiter to stop deferring.

The normal interval in clock cycles is a parameter. It is sized so that every row is refreshed once within the 64 ms retention window, which works out to 7.8 us between refreshes up to 85 °C. Above that range, a temperature flag switches the block to an interval half as long.

While the memory is in self-refresh, it refreshes itself. During that time the block stops counting, hides its request and ignores grants. When self-refresh ends, the count of owed refreshes is cleared and the interval restarts from zero. An exit-wait output then stays high for a programmable number of cycles, so the controller holds back accesses until the exit delay has passed.

Top module: `refresh_scheduler`

## Requirements
- R1: During reset and straight after it, `ref_req_o`, `ref_urgent_o` and `exit_wait_o` are low and `owed_o` is 0.
- R2: With `hot_i` low, the first refresh becomes owed at the NORM_CYC-th rising edge after reset release. Further refreshes become owed every NORM_CYC edges after that.
- R3: With `hot_i` high, the interval is HOT_CYC = NORM_CYC/2 edges.
- R4: If `hot_i` rises when the elapsed count is already at or past HOT_CYC-1, a refresh becomes owed at the very next edge.
- R5: Each elapsed interval raises `owed_o` by one. Outside self-refresh, `ref_req_o` is high exactly while `owed_o` is non-zero.
- R6: A grant taken while `owed_o` is non-zero lowers it by one. A grant while `owed_o` is 0 has no effect.
- R7: `owed_o` never exceeds MAX_OWED, and `ref_urgent_o` is high exactly when `owed_o` equals MAX_OWED. When an interval ends on the same edge as a grant, `owed_o` stays the same, even at MAX_OWED.
- R8: While `self_ref_i` is high, `ref_req_o` and `ref_urgent_o` are low, the interval does not advance, and grants leave `owed_o` unchanged.
- R9: At the first edge with `self_ref_i` low after self-refresh, `owed_o` clears. The next refresh becomes owed on the NORM_CYC-th edge counted from that edge.
- R10: `exit_wait_o` is high for exactly EXIT_CYC cycles following that exit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hot_i | input | 1 | Temperature above normal range; selects half interval |
| self_ref_i | input | 1 | Memory is in self-refresh (clock enable held low) |
| grant_i | input | 1 | Arbiter has issued one refresh this cycle |
| ref_req_o | output | 1 | At least one refresh is owed |
| ref_urgent_o | output | 1 | Owed count at its ceiling |
| owed_o | output | $clog2(MAX_OWED+1) | Number of refreshes owed |
| exit_wait_o | output | 1 | Self-refresh exit delay still running |

## Verification
The bench builds the block with NORM_CYC = 40, MAX_OWED = 8 and EXIT_CYC = 6. At those values, HOT_CYC is 20 and the owed count reaches its ceiling within a few hundred cycles. That keeps within reach saturation, a grant that coincides with an elapsed interval at the ceiling, a mid-interval switch to the short interval, and a full self-refresh entry, exit delay and restart.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    // Short interval used above the normal temperature range: half the
    // normal one, never below one cycle.
    function automatic int unsigned hot_len(input int unsigned norm_len);
        return (norm_len / 2 == 0) ? 1 : norm_len / 2;
    endfunction

    // Counter width able to hold values 0..n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
    import rfsh_pkg::*;
#(
    parameter int unsigned NORM_CYC = 6240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_i,
    input  logic hold_i,
    output logic tick_o
);
    localparam int unsigned HOT_CYC = hot_len(NORM_CYC);
    localparam int unsigned CW      = cnt_width(NORM_CYC);
    localparam logic [CW-1:0] LAST_NORM = CW'(NORM_CYC - 1);
    localparam logic [CW-1:0] LAST_HOT  = CW'(HOT_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CW-1:0] last;

    always_comb begin
        tmr_d  = tmr_q;
        last   = hot_i ? LAST_HOT : LAST_NORM;
        tick_o = 1'b0;
        if (hold_i) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt >= last) begin
            // >= also catches a switch to the short interval late in a period
            tick_o    = 1'b1;
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

endmodule

// File: rtl/rfsh_owed_tracker.sv
module rfsh_owed_tracker
    import rfsh_pkg::*;
#(
    parameter int unsigned MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic grant_i,
    input  logic freeze_i,
    input  logic clear_i,
    output logic [cnt_width(MAX_OWED)-1:0] owed_o,
    output logic full_o
);
    localparam int unsigned OW = cnt_width(MAX_OWED);
    localparam logic [OW-1:0] CEIL = OW'(MAX_OWED);

    typedef struct packed {
        logic [OW-1:0] owed;
    } own_t;

    own_t own_d, own_q;
    logic dec, inc;

    always_comb begin
        own_d = own_q;
        dec   = grant_i && (own_q.owed != '0);
        // at the ceiling a new interval only counts if a grant frees a slot
        inc   = tick_i && ((own_q.owed != CEIL) || dec);
        if (clear_i) begin
            own_d.owed = '0;
        end else if (!freeze_i) begin
            if (inc && !dec)      own_d.owed = own_q.owed + 1'b1;
            else if (dec && !inc) own_d.owed = own_q.owed - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) own_q <= '0;
        else        own_q <= own_d;
    end

    assign owed_o = own_q.owed;
    assign full_o = (own_q.owed == CEIL);

endmodule

// File: rtl/rfsh_exit_timer.sv
module rfsh_exit_timer
    import rfsh_pkg::*;
#(
    parameter int unsigned EXIT_CYC = 216
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int unsigned EW = cnt_width(EXIT_CYC);
    localparam logic [EW-1:0] LOAD = EW'(EXIT_CYC);

    typedef struct packed {
        logic [EW-1:0] left;
    } ext_t;

    ext_t ext_d, ext_q;

    always_comb begin
        ext_d = ext_q;
        if (start_i)               ext_d.left = LOAD;
        else if (ext_q.left != '0) ext_d.left = ext_q.left - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_q <= '0;
        else        ext_q <= ext_d;
    end

    assign busy_o = (ext_q.left != '0);

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
    import rfsh_pkg::*;
#(
    parameter int unsigned NORM_CYC = 6240,
    parameter int unsigned MAX_OWED = 8,
    parameter int unsigned EXIT_CYC = 216
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_i,
    input  logic self_ref_i,
    input  logic grant_i,
    output logic ref_req_o,
    output logic ref_urgent_o,
    output logic [cnt_width(MAX_OWED)-1:0] owed_o,
    output logic exit_wait_o
);
    typedef struct packed {
        logic in_sr;
    } top_t;

    top_t top_d, top_q;
    logic tick, exit_pulse, full;
    logic [cnt_width(MAX_OWED)-1:0] owed;

    always_comb begin
        top_d       = top_q;
        top_d.in_sr = self_ref_i;
        exit_pulse  = top_q.in_sr && !self_ref_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    rfsh_interval_timer #(.NORM_CYC(NORM_CYC)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .hot_i  (hot_i),
        .hold_i (self_ref_i),
        .tick_o (tick)
    );

    rfsh_owed_tracker #(.MAX_OWED(MAX_OWED)) i_owed (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .grant_i  (grant_i),
        .freeze_i (self_ref_i),
        .clear_i  (exit_pulse),
        .owed_o   (owed),
        .full_o   (full)
    );

    rfsh_exit_timer #(.EXIT_CYC(EXIT_CYC)) i_exit (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (exit_pulse),
        .busy_o  (exit_wait_o)
    );

    assign owed_o       = owed;
    assign ref_req_o    = !self_ref_i && (owed != '0);
    assign ref_urgent_o = !self_ref_i && full;

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk
    import rfsh_pkg::*;
#(
    parameter int unsigned MAX_OWED = 8
) (
    input logic clk,
    input logic rst_n,
    input logic self_ref_i,
    input logic grant_i,
    input logic ref_req_o,
    input logic ref_urgent_o,
    input logic [cnt_width(MAX_OWED)-1:0] owed_o,
    input logic exit_wait_o
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(owed_o) <= int'(MAX_OWED)); // R7

    AST_URGENT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent_o |-> ref_req_o); // R7

    AST_OWED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(owed_o) <= int'($past(owed_o)) + 1)); // R5

    AST_SR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        self_ref_i |-> (!ref_req_o && !ref_urgent_o)); // R8

    AST_SR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (self_ref_i && $past(self_ref_i)) |-> $stable(owed_o)); // R8

    AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(self_ref_i) |=> (owed_o == '0)); // R9

    AST_EXIT_WAIT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(self_ref_i) |=> exit_wait_o); // R10

    AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && owed_o == '0) |=> (int'(owed_o) <= 1)); // R6

endmodule

bind refresh_scheduler rfsh_sched_chk #(.MAX_OWED(MAX_OWED)) i_rfsh_sched_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .self_ref_i   (self_ref_i),
    .grant_i      (grant_i),
    .ref_req_o    (ref_req_o),
    .ref_urgent_o (ref_urgent_o),
    .owed_o       (owed_o),
    .exit_wait_o  (exit_wait_o)
);

// File: tb/test_refresh_scheduler.sv
module test_refresh_scheduler;
    localparam int CLK_PERIOD = 10;
    localparam int NORM = 40;
    localparam int HOT  = NORM / 2;
    localparam int MAXO = 8;
    localparam int EXIT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hot = 1'b0;
    logic sr = 1'b0;
    logic grant = 1'b0;
    logic req, urgent, exit_wait;
    logic [3:0] owed;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refresh_scheduler #(.NORM_CYC(NORM), .MAX_OWED(MAXO), .EXIT_CYC(EXIT)) i_refresh_scheduler (
        .clk(clk), .rst_n(rst_n), .hot_i(hot), .self_ref_i(sr), .grant_i(grant),
        .ref_req_o(req), .ref_urgent_o(urgent), .owed_o(owed), .exit_wait_o(exit_wait)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic hot_v);
        @(negedge clk);
        rst_n = 1'b0; hot = hot_v; sr = 1'b0; grant = 1'b0;
        edges(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R1 req", req, 0);
        chk("R1 urgent", urgent, 0);
        chk("R1 owed", owed, 0);
        chk("R1 exit_wait", exit_wait, 0);
    endtask

    task automatic t_normal();
        do_reset(1'b0);
        edges(NORM - 1);
        chk("R2 before first interval", owed, 0);
        edges(1);
        chk("R2 first interval owed", owed, 1);
        chk("R5 req with owed", req, 1);
        grant = 1'b1; edges(1); grant = 1'b0;
        chk("R6 grant decrements", owed, 0);
        chk("R5 req drops", req, 0);
        edges(NORM - 2);
        chk("R2 second interval not yet", owed, 0);
        edges(1);
        chk("R2 second interval", owed, 1);
    endtask

    task automatic t_hot();
        do_reset(1'b1);
        edges(HOT - 1);
        chk("R3 before short interval", owed, 0);
        edges(1);
        chk("R3 short interval", owed, 1);
        edges(HOT);
        chk("R5 owed accumulates", owed, 2);
        chk("R5 req held", req, 1);
    endtask

    task automatic t_hot_switch();
        do_reset(1'b0);
        edges(30);
        chk("R4 nothing owed yet", owed, 0);
        hot = 1'b1;
        edges(1);
        chk("R4 immediate tick", owed, 1);
        hot = 1'b0;
    endtask

    task automatic t_idle_grant();
        do_reset(1'b0);
        grant = 1'b1; edges(5); grant = 1'b0;
        chk("R6 idle grant ignored", owed, 0);
        chk("R6 idle grant no req", req, 0);
        edges(NORM - 5);
        chk("R6 interval unaffected", owed, 1);
    endtask

    task automatic t_saturate();
        do_reset(1'b0);
        edges(NORM * (MAXO - 1));
        chk("R7 below ceiling owed", owed, MAXO - 1);
        chk("R7 urgent low below ceiling", urgent, 0);
        edges(NORM);
        chk("R7 ceiling owed", owed, MAXO);
        chk("R7 urgent at ceiling", urgent, 1);
        edges(NORM);
        chk("R7 saturates", owed, MAXO);
        edges(NORM - 1);
        grant = 1'b1; edges(1); grant = 1'b0;
        chk("R7 tick and grant together", owed, MAXO);
        grant = 1'b1; edges(1); grant = 1'b0;
        chk("R7 grant leaves ceiling", owed, MAXO - 1);
        chk("R7 urgent drops", urgent, 0);
    endtask

    task automatic t_selfref();
        do_reset(1'b0);
        edges(NORM);
        chk("R8 owed before entry", owed, 1);
        sr = 1'b1;
        edges(1);
        chk("R8 req hidden", req, 0);
        grant = 1'b1; edges(10); grant = 1'b0;
        edges(90);
        chk("R8 owed frozen", owed, 1);
        chk("R8 req still hidden", req, 0);
        chk("R8 urgent hidden", urgent, 0);
        sr = 1'b0;
        edges(1);
        chk("R9 owed cleared", owed, 0);
        chk("R10 exit wait starts", exit_wait, 1);
        edges(EXIT - 1);
        chk("R10 exit wait last cycle", exit_wait, 1);
        edges(1);
        chk("R10 exit wait ends", exit_wait, 0);
        edges(NORM - 1 - EXIT - 1);
        chk("R9 restart not yet", owed, 0);
        edges(1);
        chk("R9 restart full interval", owed, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_normal();
        t_hot();
        t_hot_switch();
        t_idle_grant();
        t_saturate();
        t_selfref();
        finish_run();
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        finish_run();
    end

endmodule